// File: doc/BRIEF.md
# Level-Sensitive IRQ/FIQ Interrupt Controller

The block gathers a bus of level-sensitive interrupt sources and turns it into two request lines for a processor: a normal request (IRQ) and a fast request (FIQ). Sources are grouped into 32-bit banks, with three banks by default. Source n lives in bank n/32 at bit n%32. Each source has a mask bit that blocks it and a select bit that also routes it to the fast line. The block also reports a vector: the byte offset of the lowest-numbered source that is pending and unmasked.

Software reaches the state through a word-wide register port. An access is a single cycle, qualified by a write strobe or a read strobe. Reads are combinational. The pending banks copy the source levels once per clock. The enable bank, the fast-pending bank, and the base, protect and NMI words are kept for software to use; none of them feeds the request logic.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: Banked groups sit at 0x10 (pending), 0x20 (fast-pending), 0x30 (select), 0x40 (enable) and 0x50 (mask). Within a group, address bits [3:2] pick the bank. Source n maps to bank n/32, bit n%32.
- R2: A pending bit equals its source level as sampled at the previous clock edge. Writes to the pending banks change nothing.
- R3: `irq_req` is high exactly when some source is pending and its mask bit is 0. A mask write takes effect in the cycle after the strobe.
- R4: `fiq_req` is high exactly when some source is pending, unmasked and has its select bit set to 1.
- R5: The vector word at 0x00 reads (32*bank + bit) * 4 for the lowest-numbered pending unmasked source. It reads 0 when there is none.
- R6: A write to a fast-pending bank clears each bit written as 1 and keeps each bit written as 0. No source sets these bits, so they read 0.
- R7: The base word (0x04) stores the written value with bits [1:0] forced to 0. The protect word (0x08) and the NMI word (0x0C) store the full written value.
- R8: The enable banks store and read back whatever is written, and have no effect on `irq_req`, `fiq_req` or the vector.
- R9: Unmapped offsets read 0 and ignore writes. This covers bank index 3, groups above 0x5C and non-word-aligned addresses. The vector word is read-only.
- R10: Reset clears every bank, every scalar word and the vector to zero, and drops both request lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 10 | Byte address within the 0x400 register window |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; `reg_rdata` is 0 when low |
| reg_rdata | output | 32 | Read data, combinational |
| src_level | input | 96 | Interrupt source levels |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
Each source pattern targets one mistake in the request logic:
- A lone source in bank 0 checks the basic vector arithmetic.
- Sources spread across three banks, with the lower ones masked off one by one, catch a scan that starts from the wrong bank or the wrong end.
- A source at the very top bit catches an off-by-one in the bank offset.
- A source that is selected but then masked separates the fast path from the mask.

Register writes aimed at bank index 3, at the pending and vector words, and at enable tell real storage apart from addresses that are decoded but must do nothing.

// File: rtl/intc_pkg.sv
// Shared address-decode constants for the interrupt controller.
// Assumes word-wide registers and at most four banks per group.
package intc_pkg;
    localparam int GRP_SCALAR = 0;  // vector, base, protect, nmi
    localparam int GRP_PEND   = 1;
    localparam int GRP_FIQP   = 2;
    localparam int GRP_SEL    = 3;
    localparam int GRP_EN     = 4;
    localparam int GRP_MASK   = 5;

    localparam int SC_VECTOR  = 0;
    localparam int SC_BASE    = 1;
    localparam int SC_PROT    = 2;
    localparam int SC_NMI     = 3;
endpackage

// File: rtl/intc_regfile.sv
// Writable storage for the controller: select, enable, mask and
// fast-pending banks, plus the base, protect and NMI words.
// Assumes NUM_BANKS <= 4, since the bank index comes from addr[3:2].
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BANK_W-1:0]           wdata,
    output logic [NUM_BANKS*BANK_W-1:0] sel_o,
    output logic [NUM_BANKS*BANK_W-1:0] en_o,
    output logic [NUM_BANKS*BANK_W-1:0] mask_o,
    output logic [NUM_BANKS*BANK_W-1:0] fiqp_o,
    output logic [BANK_W-1:0]           base_o,
    output logic [BANK_W-1:0]           prot_o,
    output logic [BANK_W-1:0]           nmi_o
);
    localparam int GRP_W = ADDR_W - 4;

    logic [GRP_W-1:0] grp;
    logic [1:0]       bidx;
    logic             word_ok;

    // Split the address into group, bank index and alignment.
    always_comb begin
        grp     = addr[ADDR_W-1:4];
        bidx    = addr[3:2];
        word_ok = (addr[1:0] == 2'b00);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] sel_q, en_q, mask_q, fiqp_q;
        logic              hit;

        assign hit = wr_en && word_ok && (bidx == 2'(b));

        // Update one bank of each writable group.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q  <= '0;
                en_q   <= '0;
                mask_q <= '0;
                fiqp_q <= '0;
            end else if (hit) begin
                if (grp == GRP_W'(GRP_SEL))  sel_q  <= wdata;
                if (grp == GRP_W'(GRP_EN))   en_q   <= wdata;
                if (grp == GRP_W'(GRP_MASK)) mask_q <= wdata;
                if (grp == GRP_W'(GRP_FIQP)) fiqp_q <= fiqp_q & ~wdata;
            end
        end

        assign sel_o [b*BANK_W +: BANK_W] = sel_q;
        assign en_o  [b*BANK_W +: BANK_W] = en_q;
        assign mask_o[b*BANK_W +: BANK_W] = mask_q;
        assign fiqp_o[b*BANK_W +: BANK_W] = fiqp_q;

        // R6
        fiqp_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((fiqp_q & ~$past(fiqp_q)) == '0));
    end

    logic [BANK_W-1:0] base_q, prot_q, nmi_q;
    logic              sc_hit;

    assign sc_hit = wr_en && word_ok && (grp == GRP_W'(GRP_SCALAR));

    // Update the scalar words; the vector slot is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            prot_q <= '0;
            nmi_q  <= '0;
        end else if (sc_hit) begin
            if (bidx == 2'(SC_BASE)) base_q <= {wdata[BANK_W-1:2], 2'b00};
            if (bidx == 2'(SC_PROT)) prot_q <= wdata;
            if (bidx == 2'(SC_NMI))  nmi_q  <= wdata;
        end
    end

    assign base_o = base_q;
    assign prot_o = prot_q;
    assign nmi_o  = nmi_q;

    // R7
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_hit && (bidx == 2'(SC_BASE)) |=> (base_o[1:0] == 2'b00));
endmodule

// File: rtl/intc_vector_find.sv
// Finds the lowest-numbered set bit across all banks and turns it into a
// byte offset ((32*bank + bit) * 4). Outputs zero when nothing is set.
// Purely combinational; assumes BANK_W is a power of two.
module intc_vector_find #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32
) (
    input  logic [NUM_BANKS*BANK_W-1:0] active_i,
    output logic                        any_o,
    output logic [BANK_W-1:0]           vec_o
);
    localparam int LO_W = $clog2(BANK_W);

    logic [NUM_BANKS*LO_W-1:0] lo_flat;
    logic [NUM_BANKS-1:0]      hit_v;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_scan
        logic [LO_W-1:0] lo;
        logic            hit;

        // Lowest set bit inside this bank.
        always_comb begin
            lo  = '0;
            hit = 1'b0;
            for (int i = BANK_W - 1; i >= 0; i--) begin
                if (active_i[b*BANK_W + i]) begin
                    lo  = LO_W'(i);
                    hit = 1'b1;
                end
            end
        end

        assign lo_flat[b*LO_W +: LO_W] = lo;
        assign hit_v[b]                = hit;
    end

    // First bank with a hit, scanning upward from bank 0.
    always_comb begin
        vec_o = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (hit_v[b]) begin
                vec_o = BANK_W'((b * BANK_W + int'(lo_flat[b*LO_W +: LO_W])) * 4);
            end
        end
        any_o = |hit_v;
    end
endmodule

// File: rtl/irq_fiq_ctrl.sv
// Top of the interrupt controller. Samples the source levels into the
// pending banks, forms the IRQ and FIQ requests and the vector, and serves
// register reads. Requests react one clock after a source or register change.
module irq_fiq_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_wr,
    input  logic [BANK_W-1:0]           reg_wdata,
    input  logic                        reg_rd,
    output logic [BANK_W-1:0]           reg_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] src_level,
    output logic                        irq_req,
    output logic                        fiq_req
);
    localparam int NUM_SRC = NUM_BANKS * BANK_W;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int GRP_W   = ADDR_W - 4;

    logic [NUM_SRC-1:0] pend_q, sel_w, en_w, mask_w, fiqp_w, active;
    logic [BANK_W-1:0]  base_w, prot_w, nmi_w, vec_w;
    logic               any_w;

    // Copy source levels into the pending banks every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src_level;
    end

    intc_regfile #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .sel_o  (sel_w),
        .en_o   (en_w),
        .mask_o (mask_w),
        .fiqp_o (fiqp_w),
        .base_o (base_w),
        .prot_o (prot_w),
        .nmi_o  (nmi_w)
    );

    assign active = pend_q & ~mask_w;

    intc_vector_find #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_find (
        .active_i (active),
        .any_o    (any_w),
        .vec_o    (vec_w)
    );

    // Request lines from the unmasked pending set.
    always_comb begin
        irq_req = any_w;
        fiq_req = |(active & sel_w);
    end

    logic [GRP_W-1:0] rgrp;
    logic [1:0]       rbidx;

    // Read mux: scalar words by index, banks by group and bank index.
    always_comb begin
        rgrp      = reg_addr[ADDR_W-1:4];
        rbidx     = reg_addr[3:2];
        reg_rdata = '0;
        if (reg_rd && reg_addr[1:0] == 2'b00) begin
            if (rgrp == GRP_W'(GRP_SCALAR)) begin
                case (rbidx)
                    2'(SC_VECTOR): reg_rdata = vec_w;
                    2'(SC_BASE):   reg_rdata = base_w;
                    2'(SC_PROT):   reg_rdata = prot_w;
                    default:       reg_rdata = nmi_w;
                endcase
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (rbidx == 2'(b)) begin
                    if (rgrp == GRP_W'(GRP_PEND)) reg_rdata = pend_q[b*BANK_W +: BANK_W];
                    if (rgrp == GRP_W'(GRP_FIQP)) reg_rdata = fiqp_w[b*BANK_W +: BANK_W];
                    if (rgrp == GRP_W'(GRP_SEL))  reg_rdata = sel_w [b*BANK_W +: BANK_W];
                    if (rgrp == GRP_W'(GRP_EN))   reg_rdata = en_w  [b*BANK_W +: BANK_W];
                    if (rgrp == GRP_W'(GRP_MASK)) reg_rdata = mask_w[b*BANK_W +: BANK_W];
                end
            end
        end
    end

    // R2
    pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q == $past(src_level)));

    // R4
    fiq_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req |-> irq_req);

    // R5
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (vec_w == '0));

    // R5
    vec_points_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> active[vec_w[2 +: IDX_W]]);
endmodule

// File: tb/tb_irq_fiq_ctrl.sv
module tb_irq_fiq_ctrl;
    localparam int NB = 3;
    localparam int BW = 32;
    localparam int AW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [BW-1:0]   reg_wdata = '0;
    logic            reg_rd = 1'b0;
    logic [BW-1:0]   reg_rdata;
    logic [NB*BW-1:0] src_level = '0;
    logic            irq_req, fiq_req;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [BW-1:0] exp;
        string         tag;
    } rd_item_t;
    rd_item_t rd_q[$];

    always #10 clk = ~clk;  // 50 MHz

    irq_fiq_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .src_level(src_level), .irq_req(irq_req), .fiq_req(fiq_req)
    );

    task automatic chk(string tag, logic [BW-1:0] got, logic [BW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every read cycle.
    always @(negedge clk) begin
        if (reg_rd) begin
            if (rd_q.size() == 0) begin
                chk("scoreboard-empty", 32'd1, 32'd0);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                chk(it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic rd(logic [AW-1:0] a, logic [BW-1:0] exp, string tag);
        @(posedge clk); #2;
        reg_addr = a; reg_rd = 1'b1;
        rd_q.push_back('{exp, tag});
        @(posedge clk); #2;
        reg_rd = 1'b0;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [BW-1:0] d);
        @(posedge clk); #2;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic set_src(logic [NB*BW-1:0] v);
        @(posedge clk); #2;
        src_level = v;
        @(posedge clk); #2;
    endtask

    task automatic lines(logic ei, logic ef, string tag);
        @(negedge clk);
        chk({tag, " irq"}, {31'd0, irq_req}, {31'd0, ei});
        chk({tag, " fiq"}, {31'd0, fiq_req}, {31'd0, ef});
    endtask

    function automatic logic [NB*BW-1:0] bit_at(int n);
        return (NB*BW)'(1) << n;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #2;
        rst_n = 1'b1;
        // R10: reset state
        lines(1'b0, 1'b0, "R10 reset");
        rd(10'h000, 32'h0, "R10 vector reset");
        rd(10'h004, 32'h0, "R10 base reset");
        rd(10'h050, 32'h0, "R10 mask reset");

        // R1 R2 R5: single source in bank 0
        set_src(bit_at(5));
        lines(1'b1, 1'b0, "R3 src5");
        rd(10'h000, 32'h14, "R5 vector src5");
        rd(10'h010, 32'h20, "R1 pending bank0");
        // R2: pending writes ignored
        wr(10'h010, 32'hFFFF_FFFF);
        rd(10'h010, 32'h20, "R2 pending write ignored");

        // R3: masking blocks
        wr(10'h050, 32'h20);
        lines(1'b0, 1'b0, "R3 mask src5");
        rd(10'h000, 32'h0, "R5 vector masked");

        // R5: bank scan order
        set_src(bit_at(5) | bit_at(40) | bit_at(70));
        rd(10'h000, 32'h0A0, "R5 vector src40");
        wr(10'h054, 32'h100);
        rd(10'h000, 32'h118, "R5 vector src70");
        lines(1'b1, 1'b0, "R3 src70");

        // R4: fast routing, then masked
        wr(10'h038, 32'h40);
        lines(1'b1, 1'b1, "R4 select src70");
        wr(10'h058, 32'h40);
        lines(1'b0, 1'b0, "R4 masked selected src");

        // R5: top source
        set_src(bit_at(5) | bit_at(40) | bit_at(70) | bit_at(95));
        lines(1'b1, 1'b0, "R4 src95 not selected");
        rd(10'h000, 32'h17C, "R5 vector src95");
        rd(10'h018, 32'h8000_0040, "R1 pending bank2");

        // R8: enable stored, no gating
        wr(10'h040, 32'hFFFF_FFFF);
        rd(10'h040, 32'hFFFF_FFFF, "R8 enable readback");
        lines(1'b1, 1'b0, "R8 enable no effect");
        rd(10'h000, 32'h17C, "R8 vector unchanged");

        // R7: scalar words
        wr(10'h004, 32'h1234_567F);
        rd(10'h004, 32'h1234_567C, "R7 base low bits");
        wr(10'h008, 32'hDEAD_BEEF);
        rd(10'h008, 32'hDEAD_BEEF, "R7 protect");
        wr(10'h00C, 32'hA5A5_A5A5);
        rd(10'h00C, 32'hA5A5_A5A5, "R7 nmi");

        // R6: fast-pending write-1-to-clear
        wr(10'h024, 32'hFFFF_FFFF);
        rd(10'h024, 32'h0, "R6 fiq pending");

        // R9: unmapped and read-only
        wr(10'h05C, 32'hFFFF_FFFF);
        rd(10'h05C, 32'h0, "R9 bank3 read");
        rd(10'h058, 32'h40, "R9 bank3 write no alias");
        lines(1'b1, 1'b0, "R9 bank3 write no effect");
        wr(10'h000, 32'h55);
        rd(10'h000, 32'h17C, "R9 vector read-only");
        wr(10'h052, 32'hFFFF_FFFF);
        rd(10'h050, 32'h20, "R9 misaligned write");
        rd(10'h060, 32'h0, "R9 read 0x60");
        rd(10'h3FC, 32'h0, "R9 read 0x3FC");

        // R2: sources drop
        set_src('0);
        lines(1'b0, 1'b0, "R2 sources low");
        rd(10'h018, 32'h0, "R2 pending cleared");

        // R10: reset mid-run
        set_src(bit_at(1));
        @(posedge clk); #2; rst_n = 1'b0;
        @(posedge clk); #2; rst_n = 1'b1;
        rd(10'h058, 32'h0, "R10 mask cleared");
        rd(10'h038, 32'h0, "R10 select cleared");
        rd(10'h004, 32'h0, "R10 base cleared");
        rd(10'h000, 32'h4, "R10 vector after reset");

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule